// File: doc/BRIEF.md
# Sector Erase Window Timer

This block sits behind the command decoder of a flash array controller. Once the decoder reports a complete sector erase command, the block opens a timed collection window. While the window is open the host may name further sectors, in any order, and each one sets its bit in a per-sector mark vector. Each accepted sector erase command restarts the count, so the window closes only after a full quiet period.

When the quiet period ends, the block raises a one-cycle start strobe for the erase engine. It holds the marks steady and reports through a status bit that the timer has run out. The erase engine answers with a done pulse, and the block then returns to read mode. Any command other than a sector erase or an erase suspend, written while the window is open, drops every mark and returns to read mode at once. The window length is set in clock cycles from the clock frequency and the wanted window time, which is 80 µs by default.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `window_open`, `timer_expired` and `erase_start` are 0 and `sector_marks` is all zeros.
- R2: In read mode, a command with `cmd_valid`=1 and `cmd_kind`=1 (sector erase) opens the window from the next cycle, and `sector_marks` then holds only bit `cmd_sector`.
- R3: If no further sector erase arrives, `timer_expired` and `erase_start` rise exactly WIN_CYCLES cycles after the clock edge that accepted the last sector erase (WIN_CYCLES = CLK_MHZ × WINDOW_US), and `window_open` falls in the same cycle.
- R4: A sector erase accepted while the window is open sets bit `cmd_sector` in `sector_marks`, keeps the earlier bits, and restarts the full WIN_CYCLES count.
- R5: A sector erase naming a sector that is already marked leaves `sector_marks` unchanged but still restarts the count.
- R6: A command with `cmd_kind` 0 or 3 accepted while the window is open clears `sector_marks`, closes the window and never raises `erase_start`.
- R7: An erase suspend (`cmd_kind`=2) while the window is open changes nothing: the marks stay the same and the count is neither restarted nor paused.
- R8: `timer_expired` is 0 while the window is open, and it stays 1 from the start of the erase until `erase_done` is seen.
- R9: While the erase runs, every command is ignored, including sector erase: `sector_marks` and `timer_expired` are unchanged.
- R10: `erase_done` during the erase returns the block to read mode on the next cycle, with `sector_marks` cleared and `timer_expired` at 0.
- R11: A command accepted on the last cycle of the window takes priority over expiry: a sector erase restarts the window and any other command except suspend cancels it. In both cases no `erase_start` is given.
- R12: `erase_start` is high for exactly one cycle per erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_kind | input | 2 | 1 sector erase, 2 erase suspend, 0 or 3 any other command |
| cmd_sector | input | SECT_W | Sector index carried by a sector erase |
| erase_done | input | 1 | Pulse from the erase engine when all marked sectors are erased |
| window_open | output | 1 | Collection window is open |
| timer_expired | output | 1 | Status: window has run out and the erase is in progress |
| erase_start | output | 1 | One-cycle strobe that starts the erase engine |
| sector_marks | output | NUM_SECTORS | One bit per sector queued for erase |

## Verification
Two functions can fall in the same cycle: the expiry of the window and the arrival of a new command. The bench counts the cycles after an accepted sector erase and places a second command so that it is sampled on exactly the edge where the count would run out. It does this once with a sector erase and once with an illegal command. It then judges that no start strobe appears, that the status bit stays 0, and that the marks and the window show a restart in the first case and a cancel in the second. A suspend placed in the same way must not delay the expiry by even one cycle.

// File: rtl/sewin_pkg.sv
package sewin_pkg;
  typedef enum logic [1:0] {
    CMD_MISC_A     = 2'd0,
    CMD_SECT_ERASE = 2'd1,
    CMD_SUSPEND    = 2'd2,
    CMD_MISC_B     = 2'd3
  } cmd_kind_t;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sewin_state_t;
endpackage

// File: rtl/sewin_timer.sv
module sewin_timer #(
  parameter int WIN_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic last
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= '0;
    end else if (run && cnt != LAST_VAL) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/sewin_marks.sv
module sewin_marks #(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   set,
  input  logic [SECT_W-1:0]      sector,
  output logic [NUM_SECTORS-1:0] marks
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    logic hit;
    assign hit = set && (sector == SECT_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        marks[i] <= 1'b0;
      end else if (hit) begin
        marks[i] <= 1'b1;
      end else if (clr) begin
        marks[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sewin_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_W      = $clog2(NUM_SECTORS),
  parameter int CLK_MHZ     = 250,
  parameter int WINDOW_US   = 80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_kind,
  input  logic [SECT_W-1:0]      cmd_sector,
  input  logic                   erase_done,
  output logic                   window_open,
  output logic                   timer_expired,
  output logic                   erase_start,
  output logic [NUM_SECTORS-1:0] sector_marks
);
  localparam int WIN_CYCLES = CLK_MHZ * WINDOW_US;

  sewin_state_t state, nstate;
  logic is_se, is_susp, is_other;
  logic t_load, t_run, t_last;
  logic m_clr, m_set, start_nxt;

  assign is_se    = cmd_valid && (cmd_kind == CMD_SECT_ERASE);
  assign is_susp  = cmd_valid && (cmd_kind == CMD_SUSPEND);
  assign is_other = cmd_valid && !is_se && !is_susp;

  always_comb begin
    nstate    = state;
    t_load    = 1'b0;
    t_run     = 1'b0;
    m_clr     = 1'b0;
    m_set     = 1'b0;
    start_nxt = 1'b0;
    unique case (state)
      ST_READ: begin
        if (is_se) begin
          nstate = ST_WINDOW;
          t_load = 1'b1;
          m_clr  = 1'b1;
          m_set  = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (is_se) begin
          t_load = 1'b1;
          m_set  = 1'b1;
        end else if (is_other) begin
          nstate = ST_READ;
          m_clr  = 1'b1;
        end else if (t_last) begin
          nstate    = ST_ERASE;
          start_nxt = 1'b1;
        end else begin
          t_run = 1'b1;
        end
      end
      ST_ERASE: begin
        if (erase_done) begin
          nstate = ST_READ;
          m_clr  = 1'b1;
        end
      end
      default: nstate = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_READ;
      window_open   <= 1'b0;
      timer_expired <= 1'b0;
      erase_start   <= 1'b0;
    end else begin
      state         <= nstate;
      window_open   <= (nstate == ST_WINDOW);
      timer_expired <= (nstate == ST_ERASE);
      erase_start   <= start_nxt;
    end
  end

  sewin_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (t_load),
    .run  (t_run),
    .last (t_last)
  );

  sewin_marks #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_marks (
    .clk    (clk),
    .rst    (rst),
    .clr    (m_clr),
    .set    (m_set),
    .sector (cmd_sector),
    .marks  (sector_marks)
  );
endmodule

// File: rtl/sewin_checker.sv
module sewin_checker #(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_W      = 6,
  parameter int WIN_CYCLES  = 20000
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmd_valid,
  input logic [1:0]             cmd_kind,
  input logic [SECT_W-1:0]      cmd_sector,
  input logic                   erase_done,
  input logic                   window_open,
  input logic                   timer_expired,
  input logic                   erase_start,
  input logic [NUM_SECTORS-1:0] sector_marks
);
  logic se_in, other_in;
  int   open_run;

  assign se_in    = cmd_valid && (cmd_kind == 2'd1);
  assign other_in = cmd_valid && (cmd_kind != 2'd1) && (cmd_kind != 2'd2);

  always_ff @(posedge clk) begin
    if (rst || !window_open || se_in) open_run <= 0;
    else                              open_run <= open_run + 1;
  end

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
    window_open |-> (open_run < WIN_CYCLES));

  assert_marks_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
    window_open |-> (sector_marks != '0));

  assert_se_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (window_open && se_in) |=> (window_open && !timer_expired && !erase_start));

  assert_cancel_R6: assert property (@(posedge clk) disable iff (rst)
    (window_open && other_in) |=> (!window_open && sector_marks == '0 && !erase_start));

  assert_status_split_R8: assert property (@(posedge clk) disable iff (rst)
    !(window_open && timer_expired));

  assert_erase_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (timer_expired && !erase_done) |=> (timer_expired && $stable(sector_marks)));

  assert_done_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (timer_expired && erase_done) |=> (!timer_expired && sector_marks == '0));

  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  assert_start_from_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(timer_expired) |-> (erase_start && $past(window_open)));
endmodule

bind sector_erase_window sewin_checker #(
  .NUM_SECTORS(NUM_SECTORS),
  .SECT_W     (SECT_W),
  .WIN_CYCLES (CLK_MHZ * WINDOW_US)
) u_sewin_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind),
  .cmd_sector   (cmd_sector),
  .erase_done   (erase_done),
  .window_open  (window_open),
  .timer_expired(timer_expired),
  .erase_start  (erase_start),
  .sector_marks (sector_marks)
);

// File: tb/sector_erase_window_test.sv
module sector_erase_window_test;
  localparam int NS  = 16;
  localparam int SW  = 4;
  localparam int MHZ = 1;
  localparam int US  = 20;
  localparam int WIN = MHZ * US;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_kind = 2'd0;
  logic [SW-1:0] cmd_sector = '0;
  logic          erase_done = 1'b0;
  logic          window_open, timer_expired, erase_start;
  logic [NS-1:0] sector_marks;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sector_erase_window #(.NUM_SECTORS(NS), .SECT_W(SW), .CLK_MHZ(MHZ), .WINDOW_US(US)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_sector(cmd_sector), .erase_done(erase_done), .window_open(window_open),
    .timer_expired(timer_expired), .erase_start(erase_start), .sector_marks(sector_marks)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit wo, input bit te, input bit es,
                            input logic [NS-1:0] mk);
    logic [NS+2:0] act, exp;
    act = {window_open, timer_expired, erase_start, sector_marks};
    exp = {wo, te, es, mk};
    check(act === exp, req, longint'(act), longint'(exp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] kind, input logic [SW-1:0] sec);
    cmd_valid  = 1'b1;
    cmd_kind   = kind;
    cmd_sector = sec;
    @(negedge clk);
    cmd_valid  = 1'b0;
    cmd_kind   = 2'd0;
  endtask

  task automatic finish_erase();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    expect_out("R10 done returns to read", 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    expect_out("R1 reset state", 1'b0, 1'b0, 1'b0, '0);
    idle(2);
    expect_out("R1 quiet after reset", 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_single();
    logic [NS-1:0] m;
    m = NS'(1) << 3;
    send(2'd1, 4'd3);
    expect_out("R2 window opens with one mark", 1'b1, 1'b0, 1'b0, m);
    idle(WIN - 1);
    expect_out("R3 still open on last cycle", 1'b1, 1'b0, 1'b0, m);
    idle(1);
    expect_out("R3 erase starts at expiry", 1'b0, 1'b1, 1'b1, m);
    idle(1);
    expect_out("R12 start is one cycle", 1'b0, 1'b1, 1'b0, m);
    send(2'd1, 4'd5);
    expect_out("R9 sector erase ignored during erase", 1'b0, 1'b1, 1'b0, m);
    send(2'd0, 4'd0);
    expect_out("R9 other command ignored during erase", 1'b0, 1'b1, 1'b0, m);
    idle(4);
    expect_out("R8 status holds until done", 1'b0, 1'b1, 1'b0, m);
    finish_erase();
  endtask

  task automatic t_multi();
    logic [NS-1:0] m;
    m = NS'(1) << 7;
    send(2'd1, 4'd7);
    idle(5);
    send(2'd1, 4'd0);
    m |= NS'(1);
    expect_out("R4 second sector added", 1'b1, 1'b0, 1'b0, m);
    idle(WIN - 3);
    send(2'd1, 4'd15);
    m |= NS'(1) << 15;
    expect_out("R4 third sector added out of order", 1'b1, 1'b0, 1'b0, m);
    idle(WIN - 4);
    send(2'd1, 4'd7);
    expect_out("R5 duplicate leaves marks", 1'b1, 1'b0, 1'b0, m);
    idle(WIN - 1);
    expect_out("R5 duplicate restarted window", 1'b1, 1'b0, 1'b0, m);
    idle(1);
    expect_out("R4 erase after restarted window", 1'b0, 1'b1, 1'b1, m);
    finish_erase();
  endtask

  task automatic t_cancel();
    send(2'd1, 4'd2);
    send(2'd1, 4'd9);
    send(2'd3, 4'd0);
    expect_out("R6 illegal command cancels", 1'b0, 1'b0, 1'b0, '0);
    idle(WIN + 3);
    expect_out("R6 no erase after cancel", 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_suspend();
    logic [NS-1:0] m;
    m = NS'(1) << 4;
    send(2'd1, 4'd4);
    idle(3);
    send(2'd2, 4'd11);
    expect_out("R7 suspend leaves marks", 1'b1, 1'b0, 1'b0, m);
    idle(WIN - 5);
    expect_out("R7 window open before expiry", 1'b1, 1'b0, 1'b0, m);
    idle(1);
    expect_out("R7 expiry not delayed by suspend", 1'b0, 1'b1, 1'b1, m);
    finish_erase();
  endtask

  task automatic t_race();
    logic [NS-1:0] m;
    m = (NS'(1) << 1) | (NS'(1) << 6);
    send(2'd1, 4'd1);
    idle(WIN - 1);
    send(2'd1, 4'd6);
    expect_out("R11 sector erase beats expiry", 1'b1, 1'b0, 1'b0, m);
    idle(WIN - 1);
    expect_out("R11 full window after late add", 1'b1, 1'b0, 1'b0, m);
    idle(1);
    expect_out("R11 erase after late add", 1'b0, 1'b1, 1'b1, m);
    finish_erase();
    send(2'd1, 4'd8);
    idle(WIN - 1);
    send(2'd0, 4'd0);
    expect_out("R11 cancel beats expiry", 1'b0, 1'b0, 1'b0, '0);
    idle(2);
    expect_out("R11 no start after late cancel", 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_cancel();
    t_suspend();
    t_race();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule